// File: doc/BRIEF.md
# Companion-Chip Register and GPIO Block

This block is the register file of a small companion chip. A host reaches it over a simple synchronous bus that has an address, a read strobe, a write strobe, write data and 16-bit read data. The registers fall into three groups:

- Storage registers for the card socket: mode, detect, status, power and control.
- Three interrupt words (raw, mask and status). These are kept only as storage and do not generate interrupts.
- A general-purpose I/O unit with a direction register and a level register.

The GPIO unit drives a set of output pins. Each output follows the level bit only where the direction bit makes that line an output. The output pins are refreshed only when the host writes the direction register or the level register.

Each input pin passes through a synchroniser. When a synchronised input changes, the matching level bit is updated, but the output pins do not change.

A few behaviours are deliberate:

- The power register sets extra bits by itself when its trigger bit is written.
- A level write is masked by the current direction.
- The level register answers at two offsets.
- The status register comes out of reset non-zero and cannot be written.

Top module: `cmp_companion_regs`

## Requirements
- R1: After reset, every register reads 0x0000 except card status, which reads 0x0002, and all GPIO outputs are low.
- R2: Only address bits [5:0] select a register, so an address that differs only above bit 5 reaches the same register.
- R3: A write keeps only bits [15:0] of the bus data. Mode (0x00), detect (0x04), control (0x10), interrupt raw (0x14), mask (0x18) and status (0x1C) read back exactly what was last written.
- R4: A write to card power (0x0C) stores the value. When bit 7 of the value is 1, bits 15 and 6 are also set (value OR 0x8040).
- R5: Card status (0x08) ignores writes, keeps reading 0x0002, and does not flag an error.
- R6: A write to 0x24 or to 0x28 loads the level register with the data AND the current direction. Reads of 0x24 and 0x28 return the level register. A read of 0x20 returns the direction register.
- R7: After a write to direction (0x20) or to level (0x24/0x28), GPIO output bit i equals level[i] AND direction[i]. The outputs change on no other cycle.
- R8: A change on an input pin reaches the matching level bit three clock edges after the pin changes. The outputs do not change until the next direction or level write.
- R9: When a bus write to the level register and a synchronised input change take effect on the same edge, the bus write value is the one stored.
- R10: A read or write at any other offset, including an offset that is not word-aligned, changes nothing. Such a read returns 0x0000, and bus_err is high for the one cycle after the strobe. Mapped accesses leave bus_err low.
- R11: Read data appears on bus_rdata on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; bits [5:0] decode |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | BUS_W | Write data; bits above 15 are dropped |
| bus_rdata | output | 16 | Registered read data |
| bus_err | output | 1 | One-cycle decode-error flag |
| gpio_in | input | GPIO_N | GPIO input pins (asynchronous) |
| gpio_out | output | GPIO_N | GPIO output pins |

## Verification
The bench builds the block with its default parameters.

A 32-bit data bus lets it put non-zero data above bit 15 and show that those bits are dropped. A 12-bit address lets it set address bits above bit 5 and show that those bits alias. With sixteen GPIO lines, both the direction mask and the input path cover the full register width.

Two synchroniser stages fix the input latency at three edges. This lets the bench line up a level write with an input change on the same edge.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
   localparam int REG_W = 16;
   localparam int OFF_W = 6;
   typedef logic [REG_W-1:0] reg_t;
   typedef logic [OFF_W-1:0] off_t;

   localparam off_t OFF_MODE   = 6'h00;
   localparam off_t OFF_DET    = 6'h04;
   localparam off_t OFF_STAT   = 6'h08;
   localparam off_t OFF_PWR    = 6'h0C;
   localparam off_t OFF_CTL    = 6'h10;
   localparam off_t OFF_IRAW   = 6'h14;
   localparam off_t OFF_IMSK   = 6'h18;
   localparam off_t OFF_ISTA   = 6'h1C;
   localparam off_t OFF_GDIR   = 6'h20;
   localparam off_t OFF_GLVL_A = 6'h24;
   localparam off_t OFF_GLVL_B = 6'h28;

   // slots of the plain storage bank
   localparam int IDX_MODE = 0;
   localparam int IDX_DET  = 1;
   localparam int IDX_CTL  = 2;
   localparam int IDX_IRAW = 3;
   localparam int IDX_IMSK = 4;
   localparam int IDX_ISTA = 5;
   localparam int N_PLAIN  = 6;

   localparam reg_t STATUS_RST   = 16'h0002;
   localparam int   PWR_TRIG_BIT = 7;
   localparam reg_t PWR_SET_MASK = 16'h8040;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cmp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/cmp_ctrl_regs.sv
module cmp_ctrl_regs
   import cmp_pkg::*;
#(
   parameter int N = N_PLAIN
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N-1:0]           we_plain,
   input  logic                   we_pwr,
   input  reg_t                   wdata,
   output logic [N-1:0][REG_W-1:0] plain_q,
   output reg_t                   pwr_q,
   output reg_t                   stat_q
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_plain
         reg_t r;
         always_ff @(posedge clk) begin
            if (!rst_n)           r <= '0;
            else if (we_plain[i]) r <= wdata;
         end
         assign plain_q[i] = r;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      pwr_q <= '0;
      else if (we_pwr) pwr_q <= wdata | (wdata[PWR_TRIG_BIT] ? PWR_SET_MASK : '0);
   end

   // status is fixed: no write path
   assign stat_q = STATUS_RST;
endmodule

// File: rtl/cmp_gpio.sv
module cmp_gpio #(
   parameter int GPIO_N      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_dir,
   input  logic              we_lvl,
   input  logic [GPIO_N-1:0] wdata,
   input  logic [GPIO_N-1:0] pin_in,
   output logic [GPIO_N-1:0] dir_q,
   output logic [GPIO_N-1:0] lvl_q,
   output logic [GPIO_N-1:0] pin_out
);
   logic [GPIO_N-1:0] in_s, prev_q, chg;

   cmp_sync #(.W(GPIO_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_in),
      .q    (in_s)
   );

   assign chg = in_s ^ prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q   <= '0;
         lvl_q   <= '0;
         pin_out <= '0;
         prev_q  <= '0;
      end else begin
         prev_q <= in_s;
         if (we_dir) begin
            dir_q   <= wdata;
            pin_out <= lvl_q & wdata;
         end
         if (we_lvl) begin
            // bus write overrides any pin change on this edge
            lvl_q   <= wdata & dir_q;
            pin_out <= wdata & dir_q;
         end else begin
            lvl_q <= (lvl_q & ~chg) | (in_s & chg);
         end
      end
   end
endmodule

// File: rtl/cmp_companion_regs.sv
module cmp_companion_regs
   import cmp_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int BUS_W       = 32,
   parameter int GPIO_N      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   output logic              bus_err,
   input  logic [GPIO_N-1:0] gpio_in,
   output logic [GPIO_N-1:0] gpio_out
);
   generate
      if (ADDR_W < OFF_W) begin : g_bad_addr
         $error("cmp_companion_regs: ADDR_W must cover the offset bits");
      end
      if (BUS_W < REG_W) begin : g_bad_bus
         $error("cmp_companion_regs: BUS_W must be at least REG_W");
      end
      if (GPIO_N < 1 || GPIO_N > REG_W) begin : g_bad_gpio
         $error("cmp_companion_regs: GPIO_N out of range");
      end
   endgenerate

   off_t                    off;
   reg_t                    wdata16, rmux;
   logic                    mapped, we_pwr, we_dir, we_lvl;
   logic [N_PLAIN-1:0]      we_plain;
   logic [N_PLAIN-1:0][REG_W-1:0] plain_q;
   reg_t                    card_pwr, card_stat;
   logic [GPIO_N-1:0]       gpio_dir, gpio_lvl;
   reg_t                    dir_ext, lvl_ext;

   assign off     = bus_addr[OFF_W-1:0];
   assign wdata16 = bus_wdata[REG_W-1:0];
   assign dir_ext = reg_t'(gpio_dir);
   assign lvl_ext = reg_t'(gpio_lvl);

   always_comb begin
      mapped   = 1'b1;
      rmux     = '0;
      we_plain = '0;
      we_pwr   = 1'b0;
      we_dir   = 1'b0;
      we_lvl   = 1'b0;
      case (off)
         OFF_MODE: begin rmux = plain_q[IDX_MODE]; we_plain[IDX_MODE] = bus_wr; end
         OFF_DET:  begin rmux = plain_q[IDX_DET];  we_plain[IDX_DET]  = bus_wr; end
         OFF_CTL:  begin rmux = plain_q[IDX_CTL];  we_plain[IDX_CTL]  = bus_wr; end
         OFF_IRAW: begin rmux = plain_q[IDX_IRAW]; we_plain[IDX_IRAW] = bus_wr; end
         OFF_IMSK: begin rmux = plain_q[IDX_IMSK]; we_plain[IDX_IMSK] = bus_wr; end
         OFF_ISTA: begin rmux = plain_q[IDX_ISTA]; we_plain[IDX_ISTA] = bus_wr; end
         OFF_PWR:  begin rmux = card_pwr;          we_pwr = bus_wr; end
         OFF_STAT: rmux = card_stat;
         OFF_GDIR: begin rmux = dir_ext;           we_dir = bus_wr; end
         OFF_GLVL_A, OFF_GLVL_B: begin rmux = lvl_ext; we_lvl = bus_wr; end
         default:  mapped = 1'b0;
      endcase
   end

   cmp_ctrl_regs #(.N(N_PLAIN)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_plain(we_plain),
      .we_pwr  (we_pwr),
      .wdata   (wdata16),
      .plain_q (plain_q),
      .pwr_q   (card_pwr),
      .stat_q  (card_stat)
   );

   cmp_gpio #(.GPIO_N(GPIO_N), .SYNC_STAGES(SYNC_STAGES)) u_gpio (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_dir (we_dir),
      .we_lvl (we_lvl),
      .wdata  (wdata16[GPIO_N-1:0]),
      .pin_in (gpio_in),
      .dir_q  (gpio_dir),
      .lvl_q  (gpio_lvl),
      .pin_out(gpio_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         if (bus_rd) bus_rdata <= rmux;
         bus_err <= (bus_rd | bus_wr) & ~mapped;
      end
   end
endmodule

// File: rtl/cmp_companion_regs_chk.sv
module cmp_companion_regs_chk
   import cmp_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int BUS_W  = 32,
   parameter int GPIO_N = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic [REG_W-1:0]  bus_rdata,
   input logic              bus_err,
   input logic [GPIO_N-1:0] gpio_out,
   input logic [GPIO_N-1:0] gpio_dir,
   input logic [REG_W-1:0]  card_pwr
);
   // R10
   err_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(bus_rd | bus_wr));

   // R10
   unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr[5:0] > 6'h28) |=> (bus_rdata == '0 && bus_err));

   // R5
   status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr[5:0] == 6'h08) |=> (bus_rdata == 16'h0002 && !bus_err));

   // R4
   power_autoset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[5:0] == 6'h0C && bus_wdata[7]) |=> (card_pwr[15] && card_pwr[6]));

   // R7
   out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(gpio_out));

   // R7
   out_within_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gpio_out & ~gpio_dir) == '0);
endmodule

bind cmp_companion_regs cmp_companion_regs_chk #(
   .ADDR_W(ADDR_W), .BUS_W(BUS_W), .GPIO_N(GPIO_N)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_rd   (bus_rd),
   .bus_wr   (bus_wr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .bus_err  (bus_err),
   .gpio_out (gpio_out),
   .gpio_dir (gpio_dir),
   .card_pwr (card_pwr)
);

// File: tb/cmp_companion_regs_tb.sv
module cmp_companion_regs_tb;
   localparam int ADDR_W = 12;
   localparam int BUS_W  = 32;
   localparam int GPIO_N = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_rd = 1'b0;
   logic              bus_wr = 1'b0;
   logic [BUS_W-1:0]  bus_wdata = '0;
   logic [15:0]       bus_rdata;
   logic              bus_err;
   logic [GPIO_N-1:0] gpio_in = '0;
   logic [GPIO_N-1:0] gpio_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cmp_companion_regs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .GPIO_N(GPIO_N)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .gpio_in(gpio_in), .gpio_out(gpio_out)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] d,
                           output logic err);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      err = bus_err;
   endtask

   task automatic do_read(input logic [ADDR_W-1:0] a, output logic [15:0] d,
                          output logic err);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata; err = bus_err;
   endtask

   task automatic expect_reg(string req, logic [ADDR_W-1:0] a, logic [15:0] exp);
      logic [15:0] d; logic e;
      do_read(a, d, e);
      check(req, {16'h0, d}, {16'h0, exp});
   endtask

   task automatic t_reset;
      logic [15:0] d; logic e;
      check("R1 gpio_out", gpio_out, 0);
      for (int i = 0; i < 11; i++) begin
         do_read(ADDR_W'(i * 4), d, e);
         // R11: value sampled the cycle after the strobe
         check("R1/R11 reset read", d, (i == 2) ? 32'h2 : 32'h0);
         check("R10 mapped no err", e, 0);
      end
   endtask

   task automatic t_storage;
      logic e;
      do_write(12'h000, 32'h1234_5A5A, e); // R3 upper half dropped
      do_write(12'h004, 32'h0000_1111, e);
      do_write(12'h010, 32'hFFFF_2222, e);
      do_write(12'h014, 32'h0000_3333, e);
      do_write(12'h018, 32'h0000_4444, e);
      do_write(12'h01C, 32'h0000_5555, e);
      expect_reg("R3 mode", 12'h000, 16'h5A5A);
      expect_reg("R3 detect", 12'h004, 16'h1111);
      expect_reg("R3 control", 12'h010, 16'h2222);
      expect_reg("R3 irq raw", 12'h014, 16'h3333);
      expect_reg("R3 irq mask", 12'h018, 16'h4444);
      expect_reg("R3 irq status", 12'h01C, 16'h5555);
   endtask

   task automatic t_alias;
      logic e;
      do_write(12'h7C4, 32'h0000_BEEF, e); // R2 decodes to 0x04
      check("R2 alias write no err", e, 0);
      expect_reg("R2 alias read plain", 12'h004, 16'hBEEF);
      expect_reg("R2 alias read high", 12'h404, 16'hBEEF);
   endtask

   task automatic t_power;
      logic e;
      do_write(12'h00C, 32'h1234_0080, e);
      expect_reg("R4 trigger set", 12'h00C, 16'h80C0);
      do_write(12'h00C, 32'h0000_007F, e);
      expect_reg("R4 no trigger", 12'h00C, 16'h007F);
      do_write(12'h00C, 32'h0000_0001, e);
      expect_reg("R4 plain store", 12'h00C, 16'h0001);
   endtask

   task automatic t_status;
      logic e;
      do_write(12'h008, 32'h0000_FFFF, e);
      check("R5 status write no err", e, 0);
      expect_reg("R5 status unchanged", 12'h008, 16'h0002);
   endtask

   task automatic t_gpio;
      logic e;
      do_write(12'h020, 32'h0000_00FF, e);
      check("R7 out after dir (level 0)", gpio_out, 0);
      do_write(12'h024, 32'h0000_ABCD, e);
      check("R7 out after level write", gpio_out, 32'h00CD);
      expect_reg("R6 level via 0x28", 12'h028, 16'h00CD);
      do_write(12'h028, 32'h0000_1234, e);
      check("R7 out after alias write", gpio_out, 32'h0034);
      expect_reg("R6 level via 0x24", 12'h024, 16'h0034);
      expect_reg("R6 dir read", 12'h020, 16'h00FF);
      do_write(12'h020, 32'h0000_0F0F, e);
      check("R7 out after dir change", gpio_out, 32'h0004);
      expect_reg("R6 level kept over dir write", 12'h024, 16'h0034);
   endtask

   task automatic t_input;
      logic e;
      @(negedge clk);
      gpio_in = 16'h0100;
      repeat (5) @(negedge clk);
      check("R8 out unchanged by pin", gpio_out, 32'h0004);
      expect_reg("R8 level follows pin", 12'h024, 16'h0134);
      gpio_in = 16'h0000;
      repeat (5) @(negedge clk);
      expect_reg("R8 level follows pin low", 12'h024, 16'h0034);
      gpio_in = 16'h0100;
      repeat (5) @(negedge clk);
      do_write(12'h020, 32'h0000_0F0F, e);
      check("R7 refresh picks pin level", gpio_out, 32'h0104);
   endtask

   task automatic t_race;
      // pin change at n0 reaches level on the third edge; write lands on that edge
      @(negedge clk);
      gpio_in = 16'h0101;
      @(negedge clk);
      @(negedge clk);
      bus_addr = 12'h024; bus_wdata = 32'h0; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      check("R9 out from write", gpio_out, 0);
      repeat (3) @(negedge clk);
      expect_reg("R9 bus write wins", 12'h024, 16'h0000);
   endtask

   task automatic t_unmapped;
      logic [15:0] d; logic e;
      do_read(12'h02C, d, e);
      check("R10 unmapped read data", d, 0);
      check("R10 unmapped read err", e, 1);
      do_read(12'h001, d, e);
      check("R10 misaligned read data", d, 0);
      check("R10 misaligned read err", e, 1);
      @(negedge clk);
      check("R10 err one cycle", bus_err, 0);
      do_write(12'h030, 32'h0000_FFFF, e);
      check("R10 unmapped write err", e, 1);
      do_write(12'h002, 32'h0000_FFFF, e);
      check("R10 misaligned write err", e, 1);
      check("R10 outputs untouched", gpio_out, 32'h0);
      expect_reg("R10 mode untouched", 12'h000, 16'h5A5A);
      expect_reg("R10 detect untouched", 12'h004, 16'hBEEF);
      expect_reg("R10 power untouched", 12'h00C, 16'h0001);
      expect_reg("R10 dir untouched", 12'h020, 16'h0F0F);
      expect_reg("R10 level untouched", 12'h024, 16'h0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_storage();
      t_alias();
      t_power();
      t_status();
      t_gpio();
      t_input();
      t_race();
      t_unmapped();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule